// File: doc/BRIEF.md
# PCI Configuration Access Sequencer

This block carries out a single PCI configuration read or write on request. The host bridge has only a few address windows, so configuration space has no window of its own. For each request the sequencer borrows the window that normally maps prefetchable memory. First it enlarges the non-prefetchable window so that it covers and hides the borrowed one. Next it points the borrowed window at configuration space. It then makes the access and puts both windows back.

The requester presents a bus number, a device/function byte, a register offset, an access size in bytes and, for writes, the write data. These fields are captured on a one-cycle `req`. The sequencer forms the configuration address itself. On bus 0 it builds a type-0 address with a one-hot device select, split between the address and the window map register. On any other bus it builds a type-1 address. Window registers are written one at a time through a write port that waits for an acknowledge. The access itself runs on a simple request/acknowledge bus that can also return an error. When the windows are restored, the block returns read data with a one-cycle `done`.

Top module: `pcicfg_sequencer`

## Requirements
- R1: After reset `busy`, `done`, `rejected`, `reg_wr` and `bus_req` are low and `rdata` is zero.
- R2: A legal request opens the window with three register writes in this order:
  - `reg_sel`=0 (window 0 base) with `WIN0_WIDE`.
  - `reg_sel`=1 (window 1 base) with `WIN1_CFG`.
  - `reg_sel`=2 (window 1 map) with the configuration map value.
- R3: On bus 0 with slot (devfn bits 7:3) of 12 or less:
  - The access address is `CFG_BASE` + (function << 8) + (1 << (slot+11)) + offset.
  - The map value is `MAP_CFG`.
- R4: On bus 0 with slot above 12:
  - The access address is `CFG_BASE` + (function << 8) + offset, with no select bit.
  - The map value is `MAP_CFG` | (1 << (slot-5)).
- R5: On a nonzero bus:
  - The access address is `CFG_BASE` + (bus << 16) + (devfn << 8) + offset.
  - The map value is `MAP_CFG` | 1, so the low address bits come from the host.
- R6: Access sizes 1, 2 and 4 are accepted and appear on `bus_size` as 0, 1 and 2.
- R7: A write issues one bus write, with the data masked to the access width. It then issues one bus read from the same address and size. Both happen before the window is closed.
- R8: After the access the window is closed with three register writes in this order:
  - `reg_sel`=1 with `WIN1_MEM`.
  - `reg_sel`=2 with `MAP1_MEM`.
  - `reg_sel`=0 with `WIN0_STD`.
- R9: `done` is high for exactly one cycle, in the cycle after the last close acknowledge. With it, `rdata` holds the read (or read-back) data, zero-extended from the access width.
- R10: If any bus access of the request ends with `bus_err`, `rdata` is 0xFF for a byte access and 0xFFFFFFFF for 2- or 4-byte accesses.
- R11: A request is rejected if any of these holds:
  - the bus, devfn or offset is above 255;
  - the size is not 1, 2 or 4.

  A rejected request raises `done` and `rejected` in the next cycle, with `rdata` = 0xFFFFFFFF. It causes no register write and no bus access.
- R12: `busy` is high from the first window write until the window is restored. A `req` while busy is ignored.
- R13: `reg_wr`, `reg_sel` and `reg_data` hold steady until `reg_ack`. `bus_req`, `bus_addr` and `bus_size` hold steady until `bus_ack` or `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start one configuration access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 9 | Bus number (above 255 is illegal) |
| req_devfn | input | 9 | Slot in bits 7:3, function in bits 2:0 |
| req_offset | input | 9 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Window borrowed, requests ignored |
| done | output | 1 | One-cycle completion pulse |
| rejected | output | 1 | With `done`: request was illegal |
| rdata | output | 32 | Returned data |
| reg_wr | output | 1 | Window register write request |
| reg_sel | output | 2 | 0 window 0 base, 1 window 1 base, 2 window 1 map |
| reg_data | output | 32 | Value to write |
| reg_ack | input | 1 | Register write accepted |
| bus_req | output | 1 | Configuration bus access request |
| bus_we | output | 1 | Access is a write |
| bus_size | output | 2 | 0 byte, 1 half, 2 word |
| bus_addr | output | 32 | Access address |
| bus_wdata | output | 32 | Write data, masked to width |
| bus_rdata | input | 32 | Read data |
| bus_ack | input | 1 | Access finished normally |
| bus_err | input | 1 | Access aborted |

## Verification
Random requests mix bus 0 and nonzero buses, all slots, all three sizes, reads and writes, and acknowledge delays. This separates the type-0 from the type-1 address path and shows that the window register order holds under stalled handshakes.

Directed cases cover the following:
- Slots 12 and 13, which show whether the one-hot select moves from the address into the map value at the right boundary.
- Slots 0 and 31, the ends of that range.
- Aborts on byte, halfword and word accesses, and on the read-back after a write, which tell the two all-ones widths apart.
- Each field set to 256 and sizes 0 and 3, which must be rejected without touching a window.

// File: rtl/pcicfg_sequencer.sv
module pcicfg_sequencer #(
  parameter logic [31:0] CFG_BASE  = 32'h6100_0000,
  parameter logic [31:0] WIN0_STD  = 32'h4000_0091,
  parameter logic [31:0] WIN0_WIDE = 32'h4000_00A1,
  parameter logic [31:0] WIN1_CFG  = 32'h6100_0061,
  parameter logic [31:0] WIN1_MEM  = 32'h5000_0091,
  parameter logic [31:0] MAP1_MEM  = 32'h1000_0006,
  parameter logic [31:0] MAP_CFG   = 32'h0000_000A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        req_write,
  input  logic [8:0]  req_bus,
  input  logic [8:0]  req_devfn,
  input  logic [8:0]  req_offset,
  input  logic [2:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic        rejected,
  output logic [31:0] rdata,
  output logic        reg_wr,
  output logic [1:0]  reg_sel,
  output logic [31:0] reg_data,
  input  logic        reg_ack,
  output logic        bus_req,
  output logic        bus_we,
  output logic [1:0]  bus_size,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  input  logic        bus_ack,
  input  logic        bus_err
);

  typedef enum logic [3:0] {
    S_IDLE, S_OPEN0, S_OPEN1, S_OPEN2, S_XFER, S_RBACK, S_CLOSE0, S_CLOSE1, S_CLOSE2
  } st_t;

  st_t         st;
  logic [31:0] a_addr, a_map, a_wdata, a_rd;
  logic [1:0]  a_bsz;
  logic        a_we, a_err;

  logic        size_ok, illegal;
  logic [1:0]  in_bsz;
  logic [4:0]  slot;
  logic [2:0]  func;
  logic [31:0] t0_addr, t1_addr, in_addr, in_map, in_mask, a_mask;

  function automatic logic [31:0] width_mask(input logic [1:0] bsz);
    case (bsz)
      2'd0:    width_mask = 32'h0000_00FF;
      2'd1:    width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  assign size_ok = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);
  assign illegal = req_bus[8] | req_devfn[8] | req_offset[8] | ~size_ok;
  assign in_bsz  = (req_size == 3'd1) ? 2'd0 : (req_size == 3'd2) ? 2'd1 : 2'd2;
  assign in_mask = width_mask(in_bsz);
  assign a_mask  = width_mask(a_bsz);
  assign slot    = req_devfn[7:3];
  assign func    = req_devfn[2:0];

  assign t0_addr = {21'd0, func, 8'd0}
                 | ((slot <= 5'd12) ? (32'd1 << ({27'd0, slot} + 32'd11)) : 32'd0);
  assign t1_addr = {8'd0, req_bus[7:0], req_devfn[7:0], 8'd0};

  always_comb begin
    if (req_bus[7:0] == 8'd0) begin
      in_addr = t0_addr;
      in_map  = MAP_CFG | ((slot > 5'd12) ? (32'd1 << ({27'd0, slot} - 32'd5)) : 32'd0);
    end else begin
      in_addr = t1_addr;
      in_map  = MAP_CFG | 32'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      done     <= 1'b0;
      rejected <= 1'b0;
      rdata    <= 32'd0;
      a_addr   <= 32'd0;
      a_map    <= 32'd0;
      a_wdata  <= 32'd0;
      a_rd     <= 32'd0;
      a_bsz    <= 2'd0;
      a_we     <= 1'b0;
      a_err    <= 1'b0;
    end else begin
      done     <= 1'b0;
      rejected <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          if (illegal) begin
            done     <= 1'b1;
            rejected <= 1'b1;
            rdata    <= 32'hFFFF_FFFF;
          end else begin
            a_addr  <= CFG_BASE + in_addr + {23'd0, req_offset};
            a_map   <= in_map;
            a_bsz   <= in_bsz;
            a_we    <= req_write;
            a_wdata <= req_wdata & in_mask;
            a_err   <= 1'b0;
            st      <= S_OPEN0;
          end
        end
        S_OPEN0:  if (reg_ack) st <= S_OPEN1;
        S_OPEN1:  if (reg_ack) st <= S_OPEN2;
        S_OPEN2:  if (reg_ack) st <= S_XFER;
        S_XFER, S_RBACK: if (bus_ack || bus_err) begin
          a_err <= a_err | bus_err;
          a_rd  <= bus_rdata & a_mask;
          st    <= (st == S_XFER && a_we) ? S_RBACK : S_CLOSE0;
        end
        S_CLOSE0: if (reg_ack) st <= S_CLOSE1;
        S_CLOSE1: if (reg_ack) st <= S_CLOSE2;
        S_CLOSE2: if (reg_ack) begin
          st    <= S_IDLE;
          done  <= 1'b1;
          rdata <= a_err ? ((a_bsz == 2'd0) ? 32'h0000_00FF : 32'hFFFF_FFFF) : a_rd;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_sel  = 2'd0;
    reg_data = 32'd0;
    case (st)
      S_OPEN0:  begin reg_sel = 2'd0; reg_data = WIN0_WIDE; end
      S_OPEN1:  begin reg_sel = 2'd1; reg_data = WIN1_CFG;  end
      S_OPEN2:  begin reg_sel = 2'd2; reg_data = a_map;     end
      S_CLOSE0: begin reg_sel = 2'd1; reg_data = WIN1_MEM;  end
      S_CLOSE1: begin reg_sel = 2'd2; reg_data = MAP1_MEM;  end
      S_CLOSE2: begin reg_sel = 2'd0; reg_data = WIN0_STD;  end
      default:  ;
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign reg_wr    = (st == S_OPEN0) || (st == S_OPEN1) || (st == S_OPEN2) ||
                     (st == S_CLOSE0) || (st == S_CLOSE1) || (st == S_CLOSE2);
  assign bus_req   = (st == S_XFER) || (st == S_RBACK);
  assign bus_we    = (st == S_XFER) && a_we;
  assign bus_size  = a_bsz;
  assign bus_addr  = a_addr;
  assign bus_wdata = a_wdata;

endmodule

// File: rtl/pcicfg_sequencer_chk.sv
module pcicfg_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        rejected,
  input logic        reg_wr,
  input logic [1:0]  reg_sel,
  input logic [31:0] reg_data,
  input logic        reg_ack,
  input logic        bus_req,
  input logic [1:0]  bus_size,
  input logic [31:0] bus_addr,
  input logic        bus_ack,
  input logic        bus_err
);

  // R13
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !reg_ack |=> reg_wr && $stable(reg_sel) && $stable(reg_data));

  // R13
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && !bus_err |=> bus_req && $stable(bus_addr) && $stable(bus_size));

  // R12
  reg_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> busy);

  // R12
  bus_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy && !reg_wr);

  // R11
  reject_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |-> done && !busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  restore_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done && !rejected);

endmodule

bind pcicfg_sequencer pcicfg_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rejected(rejected),
  .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_data(reg_data), .reg_ack(reg_ack),
  .bus_req(bus_req), .bus_size(bus_size), .bus_addr(bus_addr),
  .bus_ack(bus_ack), .bus_err(bus_err)
);

// File: tb/pcicfg_sequencer_test.sv
`timescale 1ns/1ps
module pcicfg_sequencer_test;

  localparam logic [31:0] CFG_BASE  = 32'h6100_0000;
  localparam logic [31:0] WIN0_STD  = 32'h4000_0091;
  localparam logic [31:0] WIN0_WIDE = 32'h4000_00A1;
  localparam logic [31:0] WIN1_CFG  = 32'h6100_0061;
  localparam logic [31:0] WIN1_MEM  = 32'h5000_0091;
  localparam logic [31:0] MAP1_MEM  = 32'h1000_0006;
  localparam logic [31:0] MAP_CFG   = 32'h0000_000A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_write = 1'b0;
  logic [8:0] req_bus = '0, req_devfn = '0, req_offset = '0;
  logic [2:0] req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic busy, done, rejected;
  logic [31:0] rdata;
  logic reg_wr; logic [1:0] reg_sel; logic [31:0] reg_data;
  logic reg_ack = 1'b0;
  logic bus_req, bus_we; logic [1:0] bus_size; logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic bus_ack = 1'b0, bus_err = 1'b0;

  always #5 clk = ~clk;

  pcicfg_sequencer uut (.*);

  int checks = 0, errors = 0, cycles = 0;
  int log_n = 0, b_n = 0, done_n = 0, busy_viol = 0;
  logic [1:0]  log_sel [0:15];
  logic [31:0] log_data [0:15];
  logic [31:0] b_addr [0:3], b_wdata [0:3];
  logic [1:0]  b_size [0:3];
  logic        b_we [0:3];
  logic [31:0] rd_val = '0;
  int err_at = -1;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if ((reg_wr || bus_req) && !busy) busy_viol++;
    if (done) done_n++;
    reg_ack = reg_wr && ($urandom % 3 != 0);
    if (reg_ack && log_n < 16) begin
      log_sel[log_n] = reg_sel; log_data[log_n] = reg_data;
    end
    if (reg_ack) log_n++;
    bus_ack = 1'b0; bus_err = 1'b0;
    if (bus_req && ($urandom % 3 != 0)) begin
      if (b_n == err_at) bus_err = 1'b1; else bus_ack = 1'b1;
      bus_rdata = rd_val;
      if (b_n < 4) begin
        b_addr[b_n] = bus_addr; b_wdata[b_n] = bus_wdata;
        b_size[b_n] = bus_size; b_we[b_n] = bus_we;
      end
      b_n++;
    end
  end

  function automatic logic [31:0] exp_addr(input logic [8:0] bn, input logic [8:0] df, input logic [8:0] off);
    logic [31:0] a;
    if (bn == 0) begin
      a = {21'd0, df[2:0], 8'd0};
      if (df[7:3] <= 12) a = a + (32'd1 << (df[7:3] + 11));
    end else a = (32'(bn) << 16) + (32'(df) << 8);
    return CFG_BASE + a + 32'(off);
  endfunction

  function automatic logic [31:0] exp_map(input logic [8:0] bn, input logic [8:0] df);
    if (bn != 0) return MAP_CFG | 32'd1;
    if (df[7:3] > 12) return MAP_CFG | (32'd1 << (df[7:3] - 5));
    return MAP_CFG;
  endfunction

  function automatic logic [31:0] mask_of(input logic [2:0] sz);
    return (sz == 1) ? 32'hFF : (sz == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic op(input bit wr, input logic [8:0] bn, input logic [8:0] df,
                    input logic [8:0] off, input logic [2:0] sz, input int errpos);
    logic [31:0] wd, ea, em, er;
    logic [1:0]  ebs;
    bit bad, got;
    int wait_n;
    wd = $urandom; rd_val = $urandom;
    err_at = errpos;
    log_n = 0; b_n = 0; done_n = 0;
    bad = bn > 255 || df > 255 || off > 255 || !(sz == 1 || sz == 2 || sz == 4);
    @(negedge clk);
    log_n = 0; b_n = 0; done_n = 0;
    req = 1'b1; req_write = wr; req_bus = bn; req_devfn = df;
    req_offset = off; req_size = sz; req_wdata = wd;
    @(negedge clk);
    if (!bad) begin
      // R12: poke while busy, must be ignored
      req_bus = 9'd3; req_devfn = 9'd9; req_size = 3'd1;
      chk(busy === 1'b1, "R12 busy after accept", {31'd0, busy}, 32'd1);
      @(negedge clk);
    end
    req = 1'b0;
    got = done;
    wait_n = 0;
    while (!got && wait_n < 500) begin
      @(negedge clk); got = done; wait_n++;
    end
    chk(got, "R9 done seen", {31'd0, got}, 32'd1);
    if (bad) begin
      chk(wait_n == 0, "R11 done next cycle", wait_n, 0);
      chk(rejected === 1'b1 && rdata === 32'hFFFF_FFFF, "R11 rejected/rdata", rdata, 32'hFFFF_FFFF);
      chk(log_n == 0 && b_n == 0 && busy === 1'b0, "R11 no activity", log_n + b_n, 0);
    end else begin
      ea = exp_addr(bn, df, off); em = exp_map(bn, df);
      ebs = (sz == 1) ? 2'd0 : (sz == 2) ? 2'd1 : 2'd2;
      chk(rejected === 1'b0 && busy === 1'b0, "R12 idle at done", {30'd0, busy, rejected}, 0);
      chk(log_n == 6, "R2 R8 register write count", log_n, 6);
      if (log_n == 6) begin
        chk(log_sel[0] == 0 && log_data[0] == WIN0_WIDE, "R2 widen window 0", log_data[0], WIN0_WIDE);
        chk(log_sel[1] == 1 && log_data[1] == WIN1_CFG, "R2 window 1 to config", log_data[1], WIN1_CFG);
        chk(log_sel[2] == 2 && log_data[2] == em, "R3 R4 R5 map value", log_data[2], em);
        chk(log_sel[3] == 1 && log_data[3] == WIN1_MEM, "R8 restore window 1", log_data[3], WIN1_MEM);
        chk(log_sel[4] == 2 && log_data[4] == MAP1_MEM, "R8 restore map 1", log_data[4], MAP1_MEM);
        chk(log_sel[5] == 0 && log_data[5] == WIN0_STD, "R8 shrink window 0", log_data[5], WIN0_STD);
      end
      chk(b_n == (wr ? 2 : 1), "R7 bus access count", b_n, wr ? 2 : 1);
      chk(b_addr[0] == ea, "R3 R4 R5 address", b_addr[0], ea);
      chk(b_size[0] == ebs && b_we[0] == wr, "R6 size/dir", {29'd0, b_we[0], b_size[0]}, {29'd0, wr, ebs});
      if (wr && b_n == 2) begin
        chk(b_wdata[0] == (wd & mask_of(sz)), "R7 masked write data", b_wdata[0], wd & mask_of(sz));
        chk(b_we[1] == 0 && b_addr[1] == ea && b_size[1] == ebs, "R7 read-back", b_addr[1], ea);
      end
      if (errpos >= 0 && errpos < b_n) er = (sz == 1) ? 32'hFF : 32'hFFFF_FFFF;
      else er = rd_val & mask_of(sz);
      chk(rdata === er, (errpos >= 0) ? "R10 abort data" : "R9 read data", rdata, er);
    end
    @(negedge clk);
    chk(done === 1'b0 && done_n == 1, "R9 single done pulse", done_n, 1);
    chk(busy_viol == 0, "R12 busy during activity", busy_viol, 0);
  endtask

  initial begin
    void'($urandom(32'd2025));
    repeat (3) @(negedge clk);
    // R1
    chk(busy === 0 && done === 0 && rejected === 0 && reg_wr === 0 && bus_req === 0 && rdata === 0,
        "R1 reset state", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    op(0, 9'd0, {5'd12, 3'd5}, 9'd4, 3'd4, -1);   // R3 boundary
    op(0, 9'd0, {5'd13, 3'd1}, 9'd8, 3'd4, -1);   // R4 boundary
    op(0, 9'd0, {5'd31, 3'd7}, 9'd255, 3'd1, -1); // R4 top
    op(1, 9'd0, {5'd0, 3'd0}, 9'd2, 3'd2, -1);    // R3 bottom, R7
    op(0, 9'd255, 9'd255, 9'd0, 3'd4, -1);        // R5
    op(0, 9'd2, 9'd17, 9'd1, 3'd1, 0);            // R10 byte
    op(0, 9'd0, 9'd40, 9'd6, 3'd2, 0);            // R10 half
    op(0, 9'd0, 9'd40, 9'd0, 3'd4, 0);            // R10 word
    op(1, 9'd4, 9'd33, 9'd12, 3'd1, 1);           // R10 read-back abort
    op(0, 9'd256, 9'd0, 9'd0, 3'd4, -1);          // R11
    op(0, 9'd0, 9'd256, 9'd0, 3'd4, -1);          // R11
    op(1, 9'd0, 9'd0, 9'd256, 3'd4, -1);          // R11
    op(0, 9'd0, 9'd0, 9'd0, 3'd3, -1);            // R6 R11
    op(0, 9'd0, 9'd0, 9'd0, 3'd0, -1);            // R6 R11
    for (int i = 0; i < 80; i++) begin
      logic [8:0] bn;
      logic [2:0] sz;
      int e;
      bn = ($urandom % 2) ? 9'd0 : 9'($urandom % 256);
      sz = ($urandom % 3 == 0) ? 3'd1 : ($urandom % 2) ? 3'd2 : 3'd4;
      e  = ($urandom % 6 == 0) ? int'($urandom % 2) : -1;
      op($urandom % 2, bn, 9'($urandom % 256), 9'($urandom % 256), sz, e);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule